// File: doc/BRIEF.md
# Address Translation Result Register

This block is a system-control register slice that holds the outcome of an address translation requested by software. Register accesses arrive as a strobe with three selector fields: a major opcode, a minor register number and a variant code. One selector value loads the result register directly. Another starts a translation of the written virtual address. The block sends that address to an external translation port and waits for the physical address or fault report. It then packs the answer into the result register, which software reads back through the same access port.

The page table walk is not part of this block. Requests and responses use valid/ready handshakes. While a translation is in flight the block raises `acc_busy` and ignores every access; the requester must present the access again later. A parameter selects the newer architecture level, which changes the writable-bit mask and adds the 16 MB supersection result format.

Top module: `xlate_result_reg`

## Requirements
- R1: After reset the result register reads as zero, and `acc_busy` and `acc_illegal` are low.
- R2: An accepted access with `acc_op1` not zero pulses `acc_illegal` high for one cycle (the cycle after acceptance), returns zero read data and changes no state.
- R3: A write with `acc_crm`=4 and `acc_op1`=0 loads the result register with the write data masked by 0xFFFFF6FF when `NEWER_ARCH`=1, or by 0xFFFFF1FF when `NEWER_ARCH`=0.
- R4: A write with `acc_crm`=8, `acc_op1`=0 and `acc_op2[2]`=0 issues one request carrying the written address, with `xl_req_user`=`acc_op2[1]` and `xl_req_write`=`acc_op2[0]`. `acc_busy` stays high from the next cycle until the response is accepted, and the request fields stay stable until `xl_req_ready`.
- R5: A write with `acc_crm`=8 and `acc_op2[2]`=1 pulses `acc_illegal`, issues no request and leaves the result register unchanged.
- R6: A successful response for a normal page sets the result register to the response address with bits [11:0] cleared.
- R7: A successful response with `xl_rsp_super`=1 sets the result register to address bits [31:24] with bit 1 set and bits [23:0] otherwise zero when `NEWER_ARCH`=1. When `NEWER_ARCH`=0 it is formatted as a normal page.
- R8: A fault response sets the result register to bit 0 = 1, bits [4:1] = status[3:0], bit 6 = status[4], and every other bit zero.
- R9: A read with `acc_crm`=4, `acc_op1`=0 and `acc_op2`=0 returns the result register on `acc_rdata` in the same cycle. Every other read returns zero.
- R10: Writes with `acc_op1`=0 to any `acc_crm` other than 4 or 8 leave the result register unchanged and raise no illegal pulse.
- R11: While `acc_busy` is high, accesses are ignored and the result register holds. It changes only at the edge where the response handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | Major opcode selector |
| acc_crm | input | 4 | Minor register selector |
| acc_op2 | input | 3 | Variant selector |
| acc_wdata | input | 32 | Write data / virtual address |
| acc_rdata | output | 32 | Read data, valid in the access cycle |
| acc_busy | output | 1 | Translation in flight; accesses ignored |
| acc_illegal | output | 1 | One-cycle illegal-access pulse |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_ready | input | 1 | Translation port accepts the request |
| xl_req_va | output | 32 | Virtual address to translate |
| xl_req_user | output | 1 | Check with user privilege |
| xl_req_write | output | 1 | Check for write access |
| xl_rsp_valid | input | 1 | Translation response valid |
| xl_rsp_ready | output | 1 | Block accepts the response |
| xl_rsp_pa | input | 32 | Translated physical address |
| xl_rsp_super | input | 1 | Hit a 16 MB supersection |
| xl_rsp_fault | input | 1 | Translation failed |
| xl_rsp_status | input | 5 | Fault status code |

## Verification
The embedded assertions check four things on every cycle. Illegal accesses leave the result register alone, and so do busy cycles without a response. A request stays stable until it is taken. The fault and page formats keep their reserved bits at zero. Only the bench's scenarios can show the other behaviours. These include the exact bit packing of page, supersection and fault results, and the difference between the two masks across the two architecture settings. They also include the read decode that returns zero for every other selector, and the fact that a write presented while busy is dropped rather than applied later.

// File: rtl/xlr_pkg.sv
package xlr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RSP  = 2'd2
   } xl_state_e;

   typedef struct packed {
      logic load_par;
      logic start;
      logic illegal;
      logic read_par;
   } acc_dec_s;

endpackage

// File: rtl/xlr_decode.sv
module xlr_decode
   import xlr_pkg::*;
#(
   parameter int OP1_W     = 3,
   parameter int CRM_W     = 4,
   parameter int OP2_W     = 3,
   parameter int CRM_PAR   = 4,
   parameter int CRM_XLATE = 8
) (
   input  logic             fire,
   input  logic             write,
   input  logic [OP1_W-1:0] op1,
   input  logic [CRM_W-1:0] crm,
   input  logic [OP2_W-1:0] op2,
   output acc_dec_s         dec
);
   localparam logic [CRM_W-1:0] SEL_PAR   = CRM_W'(CRM_PAR);
   localparam logic [CRM_W-1:0] SEL_XLATE = CRM_W'(CRM_XLATE);

   generate
      if (OP2_W < 3) begin : g_bad_op2
         $error("xlr_decode: OP2_W must be at least 3");
      end
      if (CRM_PAR == CRM_XLATE) begin : g_bad_sel
         $error("xlr_decode: selectors must differ");
      end
   endgenerate

   logic grp_ok;
   logic hit_par;
   logic hit_xl;
   logic secure_var;

   always_comb begin
      grp_ok     = (op1 == '0);
      hit_par    = (crm == SEL_PAR);
      hit_xl     = (crm == SEL_XLATE);
      secure_var = op2[2];
      dec.illegal  = fire && (!grp_ok || (write && hit_xl && secure_var));
      dec.load_par = fire && grp_ok && write && hit_par;
      dec.start    = fire && grp_ok && write && hit_xl && !secure_var;
      dec.read_par = fire && grp_ok && !write && hit_par && (op2 == '0);
   end
endmodule

// File: rtl/xlr_format.sv
module xlr_format #(
   parameter int DATA_W      = 32,
   parameter int FS_W        = 5,
   parameter int PAGE_SHIFT  = 12,
   parameter int SUPER_SHIFT = 24,
   parameter bit NEWER_ARCH  = 1'b1
) (
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rsp_pa,
   input  logic              rsp_super,
   input  logic              rsp_fault,
   input  logic [FS_W-1:0]   rsp_status,
   output logic [DATA_W-1:0] wr_masked,
   output logic [DATA_W-1:0] xl_result
);
   localparam logic [DATA_W-1:0] PAGE_MASK  = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));
   localparam logic [DATA_W-1:0] SUPER_MASK = ~((DATA_W'(1) << SUPER_SHIFT) - DATA_W'(1));
   localparam int FLT_LO_W = 4;

   generate
      if (DATA_W != 32) begin : g_bad_w
         $error("xlr_format: DATA_W must be 32");
      end
      if (FS_W != 5) begin : g_bad_fs
         $error("xlr_format: FS_W must be 5");
      end
      if (SUPER_SHIFT <= PAGE_SHIFT || SUPER_SHIFT >= DATA_W) begin : g_bad_shift
         $error("xlr_format: SUPER_SHIFT must lie above PAGE_SHIFT");
      end
   endgenerate

   logic [DATA_W-1:0] page_fmt;
   logic [DATA_W-1:0] super_fmt;
   logic [DATA_W-1:0] fault_fmt;
   logic [DATA_W-1:0] ok_fmt;

   // writable-bit mask and supersection option differ per architecture level
   generate
      if (NEWER_ARCH) begin : g_newer
         localparam logic [DATA_W-1:0] WMASK =
            ~((DATA_W'(1) << 8) | (DATA_W'(1) << 11));
         assign wr_masked = wdata & WMASK;
         assign super_fmt = (rsp_pa & SUPER_MASK) | (DATA_W'(1) << 1);
         assign ok_fmt    = rsp_super ? super_fmt : page_fmt;
      end else begin : g_base
         localparam logic [DATA_W-1:0] WMASK =
            ~((DATA_W'(1) << 9) | (DATA_W'(1) << 10) | (DATA_W'(1) << 11));
         assign wr_masked = wdata & WMASK;
         assign super_fmt = '0;
         assign ok_fmt    = page_fmt;
      end
   endgenerate

   always_comb begin
      page_fmt  = rsp_pa & PAGE_MASK;
      fault_fmt = '0;
      fault_fmt[0]          = 1'b1;
      fault_fmt[FLT_LO_W:1] = rsp_status[FLT_LO_W-1:0];
      fault_fmt[6]          = rsp_status[FS_W-1];
      xl_result = rsp_fault ? fault_fmt : ok_fmt;
   end
endmodule

// File: rtl/xlr_req_ctrl.sv
module xlr_req_ctrl
   import xlr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] start_va,
   input  logic              start_user,
   input  logic              start_write,
   output logic              busy,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [DATA_W-1:0] req_va,
   output logic              req_user,
   output logic              req_write,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   output logic              rsp_fire
);
   xl_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start)     state_d = ST_REQ;
         ST_REQ:  if (req_ready) state_d = ST_RSP;
         ST_RSP:  if (rsp_valid) state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         req_va    <= '0;
         req_user  <= 1'b0;
         req_write <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start && state_q == ST_IDLE) begin
            req_va    <= start_va;
            req_user  <= start_user;
            req_write <= start_write;
         end
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign req_valid = (state_q == ST_REQ);
   assign rsp_ready = (state_q == ST_RSP);
   assign rsp_fire  = rsp_ready && rsp_valid;

   // R4: an offered request stays put until it is taken
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_va)
                                     && $stable(req_user) && $stable(req_write)));

   // R11: no new translation may start while one is in flight
   assert_no_restart_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rsp_fire) |=> busy);
endmodule

// File: rtl/xlate_result_reg.sv
module xlate_result_reg
   import xlr_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int OP1_W       = 3,
   parameter int CRM_W       = 4,
   parameter int OP2_W       = 3,
   parameter int FS_W        = 5,
   parameter int PAGE_SHIFT  = 12,
   parameter int SUPER_SHIFT = 24,
   parameter int CRM_PAR     = 4,
   parameter int CRM_XLATE   = 8,
   parameter bit NEWER_ARCH  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [OP1_W-1:0]  acc_op1,
   input  logic [CRM_W-1:0]  acc_crm,
   input  logic [OP2_W-1:0]  acc_op2,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              acc_busy,
   output logic              acc_illegal,
   output logic              xl_req_valid,
   input  logic              xl_req_ready,
   output logic [DATA_W-1:0] xl_req_va,
   output logic              xl_req_user,
   output logic              xl_req_write,
   input  logic              xl_rsp_valid,
   output logic              xl_rsp_ready,
   input  logic [DATA_W-1:0] xl_rsp_pa,
   input  logic              xl_rsp_super,
   input  logic              xl_rsp_fault,
   input  logic [FS_W-1:0]   xl_rsp_status
);
   acc_dec_s          dec;
   logic              fire;
   logic              rsp_fire;
   logic [DATA_W-1:0] wr_masked;
   logic [DATA_W-1:0] xl_result;
   logic [DATA_W-1:0] par_q;
   logic              illegal_q;

   assign fire = acc_valid && !acc_busy;

   xlr_decode #(
      .OP1_W(OP1_W), .CRM_W(CRM_W), .OP2_W(OP2_W),
      .CRM_PAR(CRM_PAR), .CRM_XLATE(CRM_XLATE)
   ) u_decode (
      .fire (fire),
      .write(acc_write),
      .op1  (acc_op1),
      .crm  (acc_crm),
      .op2  (acc_op2),
      .dec  (dec)
   );

   xlr_format #(
      .DATA_W(DATA_W), .FS_W(FS_W), .PAGE_SHIFT(PAGE_SHIFT),
      .SUPER_SHIFT(SUPER_SHIFT), .NEWER_ARCH(NEWER_ARCH)
   ) u_format (
      .wdata     (acc_wdata),
      .rsp_pa    (xl_rsp_pa),
      .rsp_super (xl_rsp_super),
      .rsp_fault (xl_rsp_fault),
      .rsp_status(xl_rsp_status),
      .wr_masked (wr_masked),
      .xl_result (xl_result)
   );

   xlr_req_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (dec.start),
      .start_va   (acc_wdata),
      .start_user (acc_op2[1]),
      .start_write(acc_op2[0]),
      .busy       (acc_busy),
      .req_valid  (xl_req_valid),
      .req_ready  (xl_req_ready),
      .req_va     (xl_req_va),
      .req_user   (xl_req_user),
      .req_write  (xl_req_write),
      .rsp_valid  (xl_rsp_valid),
      .rsp_ready  (xl_rsp_ready),
      .rsp_fire   (rsp_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_q     <= '0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= dec.illegal;
         if (rsp_fire)          par_q <= xl_result;
         else if (dec.load_par) par_q <= wr_masked;
      end
   end

   assign acc_illegal = illegal_q;
   assign acc_rdata   = dec.read_par ? par_q : '0;

   // R2 / R5: an illegal access leaves the result untouched
   assert_illegal_keeps_par_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dec.illegal |=> $stable(par_q));

   // R11: the result holds through busy cycles without a response
   assert_busy_holds_par_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_busy && !(xl_rsp_valid && xl_rsp_ready)) |=> $stable(par_q));

   // R8: fault results carry the abort flag and clear reserved bits
   assert_fault_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_rsp_valid && xl_rsp_ready && xl_rsp_fault)
      |=> (par_q[0] && !par_q[5] && par_q[DATA_W-1:7] == '0));

   // R6: page results have an empty low field
   assert_page_low_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_rsp_valid && xl_rsp_ready && !xl_rsp_fault && !xl_rsp_super)
      |=> (par_q[PAGE_SHIFT-1:0] == '0));
endmodule

// File: tb/tb_xlate_result_reg.sv
module tb_xlate_result_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [2:0]  acc_op1 = '0, acc_op2 = '0;
   logic [3:0]  acc_crm = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata, rdata_b;
   logic        acc_busy, acc_illegal, busy_b, illegal_b;
   logic        req_valid, req_ready = 1'b0, req_user, req_write;
   logic [31:0] req_va;
   logic        rsp_valid = 1'b0, rsp_ready, rsp_super = 1'b0, rsp_fault = 1'b0;
   logic [31:0] rsp_pa = '0;
   logic [4:0]  rsp_status = '0;
   logic        b_req_valid, b_req_user, b_req_write, b_rsp_ready;
   logic [31:0] b_req_va;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #5 clk = ~clk;

   xlate_result_reg #(.NEWER_ARCH(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_op1(acc_op1),
      .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .acc_busy(acc_busy), .acc_illegal(acc_illegal),
      .xl_req_valid(req_valid), .xl_req_ready(req_ready), .xl_req_va(req_va),
      .xl_req_user(req_user), .xl_req_write(req_write),
      .xl_rsp_valid(rsp_valid), .xl_rsp_ready(rsp_ready), .xl_rsp_pa(rsp_pa),
      .xl_rsp_super(rsp_super), .xl_rsp_fault(rsp_fault), .xl_rsp_status(rsp_status)
   );

   // base architecture instance: its port always answers a supersection hit
   xlate_result_reg #(.NEWER_ARCH(1'b0)) dut_base (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_op1(acc_op1),
      .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_wdata(acc_wdata),
      .acc_rdata(rdata_b), .acc_busy(busy_b), .acc_illegal(illegal_b),
      .xl_req_valid(b_req_valid), .xl_req_ready(1'b1), .xl_req_va(b_req_va),
      .xl_req_user(b_req_user), .xl_req_write(b_req_write),
      .xl_rsp_valid(1'b1), .xl_rsp_ready(b_rsp_ready), .xl_rsp_pa(32'h1234_5678),
      .xl_rsp_super(1'b1), .xl_rsp_fault(1'b0), .xl_rsp_status(5'd0)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
         finish_run();
      end
   end

   // one access; rd/rd_b sampled in the access cycle, ill after acceptance
   task automatic access(input bit wr, input logic [2:0] o1, input logic [3:0] cm,
                         input logic [2:0] o2, input logic [31:0] d,
                         output logic [31:0] rd, output logic [31:0] rd_b,
                         output logic ill);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_op1 = o1; acc_crm = cm;
      acc_op2 = o2; acc_wdata = d;
      #1 rd = acc_rdata; rd_b = rdata_b;
      @(negedge clk);
      ill = acc_illegal;
      acc_valid = 1'b0; acc_write = 1'b0; acc_op1 = '0; acc_crm = '0; acc_op2 = '0;
   endtask

   task automatic read_par(output logic [31:0] v, output logic [31:0] vb);
      logic ill;
      access(1'b0, 3'd0, 4'd4, 3'd0, 32'h0, v, vb, ill);
   endtask

   task automatic xlate(input string req, input logic [31:0] va, input logic [2:0] o2,
                        input logic [31:0] pa, input bit sup, input bit flt,
                        input logic [4:0] st, input int delay, input logic [31:0] exp);
      logic [31:0] r, rb;
      logic ill;
      access(1'b1, 3'd0, 4'd8, o2, va, r, rb, ill);
      chk({req, " R4 req_valid"}, {31'd0, req_valid}, 32'd1);
      chk({req, " R4 va"}, req_va, va);
      chk({req, " R4 user/write"}, {30'd0, req_user, req_write}, {30'd0, o2[1], o2[0]});
      chk({req, " R4 busy"}, {31'd0, acc_busy}, 32'd1);
      repeat (delay) @(negedge clk);
      chk({req, " R4 req held"}, {31'd0, req_valid}, 32'd1);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      rsp_valid = 1'b1; rsp_pa = pa; rsp_super = sup; rsp_fault = flt; rsp_status = st;
      chk({req, " R11 busy before response"}, {31'd0, acc_busy}, 32'd1);
      @(negedge clk);
      rsp_valid = 1'b0;
      chk({req, " R11 busy cleared"}, {31'd0, acc_busy}, 32'd0);
      read_par(r, rb);
      chk(req, r, exp);
   endtask

   task automatic t_reset();
      logic [31:0] r, rb;
      chk("R1 busy", {31'd0, acc_busy}, 32'd0);
      chk("R1 illegal", {31'd0, acc_illegal}, 32'd0);
      read_par(r, rb);
      chk("R1 result zero", r, 32'd0);
   endtask

   task automatic t_direct_write();
      logic [31:0] r, rb;
      logic ill;
      access(1'b1, 3'd0, 4'd4, 3'd0, 32'hFFFF_FFFF, r, rb, ill);
      read_par(r, rb);
      chk("R3 newer mask", r, 32'hFFFF_F6FF);
      chk("R3 base mask", rb, 32'hFFFF_F1FF);
      access(1'b1, 3'd0, 4'd4, 3'd0, 32'h0000_0A5A, r, rb, ill);
      read_par(r, rb);
      chk("R3 newer mask low", r, 32'h0000_025A);
   endtask

   task automatic t_illegal();
      logic [31:0] r, rb;
      logic ill;
      access(1'b1, 3'd1, 4'd4, 3'd0, 32'h1111_0000, r, rb, ill);
      chk("R2 illegal pulse write", {31'd0, ill}, 32'd1);
      access(1'b0, 3'd2, 4'd4, 3'd0, 32'h0, r, rb, ill);
      chk("R2 illegal read data zero", r, 32'd0);
      chk("R2 illegal pulse read", {31'd0, ill}, 32'd1);
      @(negedge clk);
      chk("R2 pulse one cycle", {31'd0, acc_illegal}, 32'd0);
      read_par(r, rb);
      chk("R2 result unchanged", r, 32'h0000_025A);
      access(1'b1, 3'd0, 4'd8, 3'd4, 32'h5555_0000, r, rb, ill);
      chk("R5 illegal pulse", {31'd0, ill}, 32'd1);
      chk("R5 no request", {31'd0, req_valid}, 32'd0);
      chk("R5 not busy", {31'd0, acc_busy}, 32'd0);
      read_par(r, rb);
      chk("R5 result unchanged", r, 32'h0000_025A);
   endtask

   task automatic t_other_sel();
      logic [31:0] r, rb;
      logic ill;
      access(1'b1, 3'd0, 4'd5, 3'd0, 32'hABCD_EF01, r, rb, ill);
      chk("R10 no illegal", {31'd0, ill}, 32'd0);
      access(1'b1, 3'd0, 4'd10, 3'd4, 32'hABCD_EF01, r, rb, ill);
      read_par(r, rb);
      chk("R10 result unchanged", r, 32'h0000_025A);
      access(1'b0, 3'd0, 4'd4, 3'd1, 32'h0, r, rb, ill);
      chk("R9 read op2!=0 zero", r, 32'd0);
      access(1'b0, 3'd0, 4'd8, 3'd0, 32'h0, r, rb, ill);
      chk("R9 read crm8 zero", r, 32'd0);
   endtask

   task automatic t_translate();
      logic [31:0] r, rb;
      xlate("R6 page read priv", 32'h0040_1234, 3'd0, 32'h8765_4321, 1'b0, 1'b0, 5'd0, 0,
            32'h8765_4000);
      xlate("R6 page user write", 32'hC000_0FFF, 3'd3, 32'h0000_1FFF, 1'b0, 1'b0, 5'd0, 3,
            32'h0000_1000);
      xlate("R7 supersection newer", 32'h1000_0000, 3'd2, 32'hAB12_3456, 1'b1, 1'b0, 5'd0, 1,
            32'hAB00_0002);
      read_par(r, rb);
      chk("R7 base arch formats as page", rb, 32'h1234_5000);
      xlate("R8 fault low status", 32'h0, 3'd1, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'h0D, 0,
            32'h0000_001B);
      xlate("R8 fault high status", 32'h0, 3'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, 5'h16, 2,
            32'h0000_004D);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] r, rb;
      logic ill;
      access(1'b1, 3'd0, 4'd8, 3'd0, 32'h2000_0000, r, rb, ill);
      chk("R11 busy", {31'd0, acc_busy}, 32'd1);
      access(1'b1, 3'd0, 4'd4, 3'd0, 32'hDEAD_0000, r, rb, ill);
      access(1'b1, 3'd1, 4'd4, 3'd0, 32'h0, r, rb, ill);
      chk("R11 illegal ignored while busy", {31'd0, ill}, 32'd0);
      access(1'b0, 3'd0, 4'd4, 3'd0, 32'h0, r, rb, ill);
      chk("R11 read while busy zero", r, 32'd0);
      @(negedge clk);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      rsp_valid = 1'b1; rsp_pa = 32'h0ABC_D777; rsp_super = 1'b0; rsp_fault = 1'b0;
      @(negedge clk);
      rsp_valid = 1'b0;
      read_par(r, rb);
      chk("R11 write during busy dropped", r, 32'h0ABC_D000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct_write();
      t_illegal();
      t_other_sel();
      t_translate();
      t_busy_ignore();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule